// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine of a small 32-bit load/store processor whose instructions are all one word long and carry a 4-bit opcode. Once reset has been honoured, it fetches a word from program ROM into an instruction register and splits that word into fields during a decode cycle. It then walks through a short chain of one-clock states for the instruction's class and returns to fetch. Each state drives the register-file write enable, the operand-B multiplexer, the ALU function select, the write-back source and the data-memory read and write strobes.

The register file, the ALU and the memories sit outside the block. The block supplies only their control and addressing. Thirteen opcodes are defined: one load, one store, seven two-source ALU operations and four one-source shift/rotate operations. The three remaining codes fall back to fetch. A reset request is taken only after the reset input has stayed high for a programmable number of consecutive clock edges, so a brief glitch does not disturb a running program.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: Reset is honoured only at the clock edge where `rst` has been sampled high on RST_HOLD consecutive edges, including that one (default 3). From that cycle on, `imem_addr` is 0 and `imem_rd`, `rf_we`, `dmem_rd`, `dmem_wr`, `opb_imm`, `wb_mem` and `alu_sel` are all 0.
- R2: A pulse on `rst` that covers fewer than RST_HOLD consecutive edges has no effect, and instruction execution continues cycle for cycle as if it had not occurred.
- R3: While `rst` stays high beyond the hold, the outputs stay idle. The first cycle after `rst` falls is a fetch from address 0.
- R4: A fetch lasts one cycle, with `imem_rd`=1 and `imem_addr` equal to the program counter. The following fetch uses the address plus one.
- R5: The cycle after a fetch is a decode cycle with no strobe asserted. From that cycle on, the field outputs carry the fetched word: `rf_wa`=bits 27:24, `rf_ra`=bits 23:20, `rf_rb`=bits 19:16 and `imm`=bits 15:0. The opcode is bits 31:28.
- R6: Opcode 0 (load) runs three cycles after decode. First an address cycle with `alu_sel`=2 and `opb_imm`=1. Then a cycle with `dmem_rd`=1. Then a cycle with `rf_we`=1 and `wb_mem`=1. The next cycle is a fetch.
- R7: Opcode 1 (store) runs two cycles after decode: the same address cycle as a load, then a cycle with `dmem_wr`=1. The next cycle is a fetch.
- R8: Opcodes 2 to 8 (two-source ALU) run an execute cycle with `alu_sel` equal to the opcode and `opb_imm`=0, then a cycle with `rf_we`=1 and `wb_mem`=0. The next cycle is a fetch.
- R9: Opcodes 9 to 12 (one-source shift/rotate, amount taken from `imm`) run an execute cycle with `alu_sel` equal to the opcode and `opb_imm`=1, then a cycle with `rf_we`=1. The next cycle is a fetch.
- R10: Opcodes 13 to 15 are undefined. The cycle after decode is a fetch, and no strobe is asserted in between.
- R11: In any cycle at most one of `imem_rd`, `rf_we`, `dmem_rd` and `dmem_wr` is high. Data memory is strobed only by load and store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Reset request; honoured after RST_HOLD consecutive high samples |
| imem_addr | output | PC_W | Program counter, word address into program ROM |
| imem_rd | output | 1 | Program ROM read strobe (fetch cycle) |
| imem_data | input | WORD_W | Instruction word returned by program ROM during fetch |
| rf_ra | output | REG_AW | Register-file read address A (first source) |
| rf_rb | output | REG_AW | Register-file read address B (second source) |
| rf_wa | output | REG_AW | Register-file write address (destination) |
| rf_we | output | 1 | Register-file write enable |
| imm | output | IMM_W | Immediate / address offset / shift amount field |
| opb_imm | output | 1 | ALU operand B select: 1 = immediate, 0 = register B |
| alu_sel | output | OPC_W | ALU function select |
| wb_mem | output | 1 | Write-back source: 1 = data memory, 0 = ALU |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_wr | output | 1 | Data memory write strobe |

## Verification
If the state register holds a wrong value, the fault shows at the ports within one cycle. A strobe fires in a cycle where the class schedule forbids it, or the write-back and fetch that must close each sequence are missing, so the following fetch arrives early, arrives late, or never comes. A corrupted program counter or instruction register shows at the next fetch address or in the decode-cycle field outputs. A faulty reset qualifier either drops the fetch stream back to address 0 after a short glitch, or leaves strobes active after a full hold. Every opcode is driven under two different field patterns, so each class schedule is compared cycle by cycle, and the reset filter is exercised just below and at the threshold.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

   typedef enum logic [3:0] {
      S_RESET  = 4'd0,
      S_FETCH  = 4'd1,
      S_DECODE = 4'd2,
      S_LD_ADR = 4'd3,
      S_LD_MEM = 4'd4,
      S_LD_WB  = 4'd5,
      S_ST_ADR = 4'd6,
      S_ST_MEM = 4'd7,
      S_EX2    = 4'd8,
      S_WB2    = 4'd9,
      S_EX1    = 4'd10,
      S_WB1    = 4'd11
   } seq_state_t;

   typedef enum logic [2:0] {
      C_LOAD  = 3'd0,
      C_STORE = 3'd1,
      C_ALU2  = 3'd2,
      C_ALU1  = 3'd3,
      C_BAD   = 3'd4
   } op_class_t;

   localparam logic [3:0] OP_LOAD       = 4'd0;
   localparam logic [3:0] OP_STORE      = 4'd1;
   localparam logic [3:0] OP_ADD        = 4'd2;
   localparam logic [3:0] OP_ALU2_LAST  = 4'd8;
   localparam logic [3:0] OP_ALU1_FIRST = 4'd9;
   localparam logic [3:0] OP_ALU1_LAST  = 4'd12;

   typedef struct packed {
      logic       imem_rd;
      logic       rf_we;
      logic       dmem_rd;
      logic       dmem_wr;
      logic       opb_imm;
      logic       wb_mem;
      logic [3:0] alu_sel;
   } ctl_t;

endpackage

// File: rtl/seqc_rst_qual.sv
module seqc_rst_qual #(
   parameter int HOLD = 3
) (
   input  logic clk,
   input  logic rst,
   output logic take
);

   generate
      if (HOLD <= 8) begin : g_shift
         logic [HOLD-2:0] hist;
         always_ff @(posedge clk) begin
            hist[0] <= rst;
            for (int i = 1; i <= HOLD - 2; i++) begin
               hist[i] <= hist[i-1];
            end
         end
         assign take = rst & (&hist);
      end else begin : g_count
         localparam int CW = $clog2(HOLD);
         localparam logic [CW-1:0] LIM = CW'(HOLD - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst)          cnt <= '0;
            else if (cnt != LIM) cnt <= cnt + CW'(1);
         end
         assign take = rst & (cnt == LIM);
      end
   endgenerate

endmodule

// File: rtl/seqc_decode.sv
module seqc_decode
   import seqc_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int OPC_W  = 4,
   parameter int REG_AW = 4,
   parameter int IMM_W  = WORD_W - OPC_W - 3 * REG_AW
) (
   input  logic [WORD_W-1:0] ir,
   output logic [OPC_W-1:0]  opcode,
   output logic [REG_AW-1:0] rd,
   output logic [REG_AW-1:0] rs1,
   output logic [REG_AW-1:0] rs2,
   output logic [IMM_W-1:0]  imm,
   output op_class_t         cls
);

   localparam int RD_LSB  = WORD_W - OPC_W - REG_AW;
   localparam int RS1_LSB = RD_LSB - REG_AW;
   localparam int RS2_LSB = RS1_LSB - REG_AW;

   assign opcode = ir[WORD_W-1 -: OPC_W];
   assign rd     = ir[RD_LSB  +: REG_AW];
   assign rs1    = ir[RS1_LSB +: REG_AW];
   assign rs2    = ir[RS2_LSB +: REG_AW];
   assign imm    = ir[IMM_W-1:0];

   always_comb begin
      if (opcode == OP_LOAD)                                   cls = C_LOAD;
      else if (opcode == OP_STORE)                             cls = C_STORE;
      else if (opcode >= OP_ADD && opcode <= OP_ALU2_LAST)     cls = C_ALU2;
      else if (opcode >= OP_ALU1_FIRST && opcode <= OP_ALU1_LAST) cls = C_ALU1;
      else                                                     cls = C_BAD;
   end

endmodule

// File: rtl/seqc_next.sv
module seqc_next
   import seqc_pkg::*;
(
   input  seq_state_t state,
   input  op_class_t  cls,
   input  logic       take_rst,
   output seq_state_t nxt
);

   always_comb begin
      if (take_rst) begin
         nxt = S_RESET;
      end else begin
         case (state)
            S_RESET:  nxt = S_FETCH;
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
               case (cls)
                  C_LOAD:  nxt = S_LD_ADR;
                  C_STORE: nxt = S_ST_ADR;
                  C_ALU2:  nxt = S_EX2;
                  C_ALU1:  nxt = S_EX1;
                  default: nxt = S_FETCH;
               endcase
            end
            S_LD_ADR: nxt = S_LD_MEM;
            S_LD_MEM: nxt = S_LD_WB;
            S_ST_ADR: nxt = S_ST_MEM;
            S_EX2:    nxt = S_WB2;
            S_EX1:    nxt = S_WB1;
            default:  nxt = S_FETCH;
         endcase
      end
   end

endmodule

// File: rtl/seqc_outs.sv
module seqc_outs
   import seqc_pkg::*;
(
   input  seq_state_t state,
   input  logic [3:0] opcode,
   output ctl_t       ctl
);

   always_comb begin
      ctl = '0;
      case (state)
         S_FETCH:  ctl.imem_rd = 1'b1;
         S_LD_ADR, S_ST_ADR: begin
            ctl.alu_sel = OP_ADD;
            ctl.opb_imm = 1'b1;
         end
         S_LD_MEM: ctl.dmem_rd = 1'b1;
         S_LD_WB: begin
            ctl.rf_we  = 1'b1;
            ctl.wb_mem = 1'b1;
         end
         S_ST_MEM: ctl.dmem_wr = 1'b1;
         S_EX2:    ctl.alu_sel = opcode;
         S_EX1: begin
            ctl.alu_sel = opcode;
            ctl.opb_imm = 1'b1;
         end
         S_WB2, S_WB1: ctl.rf_we = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
   import seqc_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int OPC_W    = 4,
   parameter int REG_AW   = 4,
   parameter int PC_W     = 8,
   parameter int RST_HOLD = 3,
   parameter int IMM_W    = WORD_W - OPC_W - 3 * REG_AW
) (
   input  logic              clk,
   input  logic              rst,
   output logic [PC_W-1:0]   imem_addr,
   output logic              imem_rd,
   input  logic [WORD_W-1:0] imem_data,
   output logic [REG_AW-1:0] rf_ra,
   output logic [REG_AW-1:0] rf_rb,
   output logic [REG_AW-1:0] rf_wa,
   output logic              rf_we,
   output logic [IMM_W-1:0]  imm,
   output logic              opb_imm,
   output logic [OPC_W-1:0]  alu_sel,
   output logic              wb_mem,
   output logic              dmem_rd,
   output logic              dmem_wr
);

   generate
      if (OPC_W != 4) begin : g_bad_opc
         $error("cpu_seq_ctrl: opcode field must be 4 bits for 13 instructions");
      end
      if (IMM_W < 1) begin : g_bad_imm
         $error("cpu_seq_ctrl: word too narrow for the field layout");
      end
      if (RST_HOLD < 2) begin : g_bad_hold
         $error("cpu_seq_ctrl: reset hold must be at least two clocks");
      end
   endgenerate

   seq_state_t        state, nxt;
   op_class_t         cls;
   ctl_t              ctl;
   logic [PC_W-1:0]   pc;
   logic [WORD_W-1:0] ir;
   logic [OPC_W-1:0]  opcode;
   logic              take_rst;

   seqc_rst_qual #(.HOLD(RST_HOLD)) u_rq (
      .clk  (clk),
      .rst  (rst),
      .take (take_rst)
   );

   seqc_decode #(
      .WORD_W (WORD_W),
      .OPC_W  (OPC_W),
      .REG_AW (REG_AW),
      .IMM_W  (IMM_W)
   ) u_dec (
      .ir     (ir),
      .opcode (opcode),
      .rd     (rf_wa),
      .rs1    (rf_ra),
      .rs2    (rf_rb),
      .imm    (imm),
      .cls    (cls)
   );

   seqc_next u_nxt (
      .state    (state),
      .cls      (cls),
      .take_rst (take_rst),
      .nxt      (nxt)
   );

   seqc_outs u_out (
      .state  (state),
      .opcode (opcode),
      .ctl    (ctl)
   );

   always_ff @(posedge clk) begin
      state <= nxt;
      if (take_rst) begin
         pc <= '0;
         ir <= '0;
      end else if (state == S_FETCH) begin
         ir <= imem_data;
         pc <= pc + PC_W'(1);
      end
   end

   assign imem_addr = pc;
   assign imem_rd   = ctl.imem_rd;
   assign rf_we     = ctl.rf_we;
   assign dmem_rd   = ctl.dmem_rd;
   assign dmem_wr   = ctl.dmem_wr;
   assign opb_imm   = ctl.opb_imm;
   assign wb_mem    = ctl.wb_mem;
   assign alu_sel   = ctl.alu_sel;

endmodule

// File: rtl/seqc_chk.sv
module seqc_chk #(
   parameter int PC_W     = 8,
   parameter int OPC_W    = 4,
   parameter int RST_HOLD = 3
) (
   input logic             clk,
   input logic             rst,
   input logic [PC_W-1:0]  imem_addr,
   input logic             imem_rd,
   input logic             rf_we,
   input logic             opb_imm,
   input logic [OPC_W-1:0] alu_sel,
   input logic             wb_mem,
   input logic             dmem_rd,
   input logic             dmem_wr
);

   int unsigned rcnt  = 0;
   logic        took  = 1'b0;
   logic        armed = 1'b0;

   always_ff @(posedge clk) begin
      if (!rst)                rcnt <= 0;
      else if (rcnt < RST_HOLD) rcnt <= rcnt + 1;
      took  <= rst && (rcnt >= RST_HOLD - 1);
      armed <= armed | took;
   end

   // R1: the cycle after a full hold shows the idle reset state
   always_ff @(posedge clk) begin
      if (took) begin
         a_r1_reset_idle: assert (imem_addr == '0 && !imem_rd && !rf_we &&
                                  !dmem_rd && !dmem_wr && !opb_imm &&
                                  !wb_mem && alu_sel == '0);
      end
   end

   a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst || !armed)
      $onehot0({imem_rd, rf_we, dmem_rd, dmem_wr}));

   a_r4_pc_step: assert property (@(posedge clk) disable iff (rst || !armed)
      imem_rd |=> (!imem_rd && imem_addr == $past(imem_addr) + PC_W'(1)));

   a_r6_load_wb: assert property (@(posedge clk) disable iff (rst || !armed)
      dmem_rd |=> (rf_we && wb_mem));

   a_r6_addr_before_mem: assert property (@(posedge clk) disable iff (rst || !armed)
      (dmem_rd || dmem_wr) |-> $past(opb_imm && alu_sel == OPC_W'(2)));

   a_r7_store_ret: assert property (@(posedge clk) disable iff (rst || !armed)
      dmem_wr |=> imem_rd);

   a_r8_wb_ret: assert property (@(posedge clk) disable iff (rst || !armed)
      rf_we |=> imem_rd);

endmodule

bind cpu_seq_ctrl seqc_chk #(
   .PC_W     (PC_W),
   .OPC_W    (OPC_W),
   .RST_HOLD (RST_HOLD)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .imem_addr (imem_addr),
   .imem_rd   (imem_rd),
   .rf_we     (rf_we),
   .opb_imm   (opb_imm),
   .alu_sel   (alu_sel),
   .wb_mem    (wb_mem),
   .dmem_rd   (dmem_rd),
   .dmem_wr   (dmem_wr)
);

// File: tb/sim_cpu_seq_ctrl.sv
module sim_cpu_seq_ctrl;

   logic        clk = 1'b0;
   logic        rst = 1'b0;
   logic [7:0]  imem_addr;
   logic        imem_rd;
   logic [31:0] imem_data;
   logic [3:0]  rf_ra, rf_rb, rf_wa;
   logic        rf_we;
   logic [15:0] imm;
   logic        opb_imm;
   logic [3:0]  alu_sel;
   logic        wb_mem;
   logic        dmem_rd;
   logic        dmem_wr;

   logic [31:0] rom [32];
   int          n_chk  = 0;
   int          n_fail = 0;
   int          short_left = 0;

   always #5 clk = ~clk;

   assign imem_data = rom[imem_addr[4:0]];

   cpu_seq_ctrl u0 (
      .clk       (clk),
      .rst       (rst),
      .imem_addr (imem_addr),
      .imem_rd   (imem_rd),
      .imem_data (imem_data),
      .rf_ra     (rf_ra),
      .rf_rb     (rf_rb),
      .rf_wa     (rf_wa),
      .rf_we     (rf_we),
      .imm       (imm),
      .opb_imm   (opb_imm),
      .alu_sel   (alu_sel),
      .wb_mem    (wb_mem),
      .dmem_rd   (dmem_rd),
      .dmem_wr   (dmem_wr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // compare control outputs of the current cycle, then advance one cycle
   task automatic cyc(input string req, input string what, input bit ird,
                      input bit we, input bit drd, input bit dwr,
                      input bit opb, input bit wbm, input logic [3:0] alu);
      logic [9:0] act, exp;
      act = {imem_rd, rf_we, dmem_rd, dmem_wr, opb_imm, wb_mem, alu_sel};
      exp = {ird, we, drd, dwr, opb, wbm, alu};
      chk(act == exp, req, what, 64'(act), 64'(exp));
      if (short_left > 0) begin
         short_left--;
         if (short_left == 0) rst = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic run_instr(input int idx);
      logic [31:0] w;
      logic [3:0]  op;
      w  = rom[idx];
      op = w[31:28];
      chk(imem_addr == 8'(idx), "R4", "fetch address", 64'(imem_addr), 64'(idx));
      cyc("R4", "fetch strobes", 1, 0, 0, 0, 0, 0, 4'd0);
      chk({rf_wa, rf_ra, rf_rb, imm} == w[27:0], "R5", "decoded fields",
          64'({rf_wa, rf_ra, rf_rb, imm}), 64'(w[27:0]));
      cyc("R5", "decode idle", 0, 0, 0, 0, 0, 0, 4'd0);
      if (op == 4'd0) begin
         cyc("R6", "load address", 0, 0, 0, 0, 1, 0, 4'd2);
         cyc("R6", "load read",    0, 0, 1, 0, 0, 0, 4'd0);
         cyc("R6", "load write",   0, 1, 0, 0, 0, 1, 4'd0);
      end else if (op == 4'd1) begin
         cyc("R7", "store address", 0, 0, 0, 0, 1, 0, 4'd2);
         cyc("R7", "store write",   0, 0, 0, 1, 0, 0, 4'd0);
      end else if (op <= 4'd8) begin
         cyc("R8", "alu2 execute", 0, 0, 0, 0, 0, 0, op);
         cyc("R8", "alu2 write",   0, 1, 0, 0, 0, 0, 4'd0);
      end else if (op <= 4'd12) begin
         cyc("R9", "alu1 execute", 0, 0, 0, 0, 1, 0, op);
         cyc("R9", "alu1 write",   0, 1, 0, 0, 0, 0, 4'd0);
      end else begin
         chk(imem_rd == 1'b1 && imem_addr == 8'(idx + 1), "R10",
             "undefined returns to fetch", 64'({imem_rd, imem_addr}),
             64'({1'b1, 8'(idx + 1)}));
      end
      // R11 / R4: the next cycle is the fetch of the following word
      chk(imem_rd == 1'b1 && imem_addr == 8'(idx + 1), "R11",
          "sequence ends in fetch", 64'({imem_rd, imem_addr}),
          64'({1'b1, 8'(idx + 1)}));
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) begin
         logic [3:0] op;
         op = (i < 16) ? 4'(i) : 4'(31 - i);
         rom[i] = {op, 4'(i), ~4'(i), 4'(i * 3), 16'(i * 16'h0431) ^ 16'hA5C3};
      end
      repeat (3) @(negedge clk);

      // R1 / R3: hold reset for five edges
      rst = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         if (k >= 3) begin
            chk({imem_rd, rf_we, dmem_rd, dmem_wr, opb_imm, wb_mem, alu_sel, imem_addr} == '0,
                (k == 3) ? "R1" : "R3", "reset idle",
                64'({imem_rd, rf_we, dmem_rd, dmem_wr, opb_imm, wb_mem, alu_sel, imem_addr}), 64'(0));
         end
      end
      rst = 1'b0;
      @(negedge clk);
      chk(imem_rd == 1'b1 && imem_addr == 8'd0, "R3", "first fetch after release",
          64'({imem_rd, imem_addr}), 64'({1'b1, 8'd0}));

      for (int i = 0; i < 32; i++) begin
         if (i == 5) begin
            // R2: two-edge pulse must be ignored
            rst = 1'b1;
            short_left = 3;
         end
         run_instr(i);
      end

      // R1: full hold in mid-program restarts at address 0
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk({imem_rd, rf_we, dmem_rd, dmem_wr, imem_addr} == '0, "R1", "mid-run reset idle",
          64'({imem_rd, rf_we, dmem_rd, dmem_wr, imem_addr}), 64'(0));
      rst = 1'b0;
      @(negedge clk);
      chk(imem_rd == 1'b1 && imem_addr == 8'd0, "R3", "restart fetch",
          64'({imem_rd, imem_addr}), 64'({1'b1, 8'd0}));
      run_instr(0);
      run_instr(1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule